// File: doc/BRIEF.md
# Multi-Retire Reorder Buffer

This block keeps the program order of in-flight instructions in an out-of-order core. Dispatch writes up to three instructions per cycle into a circular buffer and receives a tag for each one. Execution units report each result by tag, in any order, together with an exception flag and a branch-mispredict flag. The buffer then hands completed instructions to the rename map in program order, up to three per cycle. A head entry that has not completed holds back every younger entry.

When the oldest entry carries a fault, the buffer empties itself. A control state machine has two states. `ST_RUN` is normal operation. `ST_FLUSH` is a single cycle in which the flush is signalled. There are two transitions:

- `ST_RUN -> ST_FLUSH`: taken at the clock edge that ends the cycle in which the head is valid, completed and faulting. In that cycle nothing retires.
- `ST_FLUSH -> ST_RUN`: always taken after one cycle. The buffer is then empty and tags restart at zero.

During `ST_FLUSH` the fault type decides the outputs. A mispredicted branch retires on lane 0 and the corrected target is sent to fetch. An exception retires nothing and raises a handler request with the faulting PC.

Top module: `rob_core`

## Requirements
- R1: After reset the buffer is empty: no retire lane valid, no flush, dispatch ready high, and the offered tags are 0, 1, 2 on lanes 0 to 2.
- R2: Dispatch lanes must be valid from lane 0 upward without gaps. Lane i is given tag (tail + i) mod DEPTH, and the tail advances by the number of valid lanes when dispatch is ready.
- R3: Dispatch ready is low while fewer than DISP_W entries are free, and dispatch offered while ready is low is not written: the tail does not move. Occupancy never exceeds DEPTH.
- R4: A completion marks its tagged entry done with its result and flags. A completion to an empty slot, or to an entry that is already done, is ignored.
- R5: Completed entries leave the buffer in program order, at most RET_W per cycle. Valid retire lanes are contiguous from lane 0 and carry consecutive tags. Retire outputs are combinational from the entry state: they appear in the cycle after the completing clock edge, and the head advances at the next edge.
- R6: An incomplete head blocks retirement of every younger entry, even entries that are already done.
- R7: Retirement within a cycle stops before the first faulting entry, and the older done entries in front of it still retire in that cycle.
- R8: A head that completed with its exception flag set stays in the buffer for one `ST_RUN` cycle with nothing retiring. The following cycle is a single `ST_FLUSH` cycle with flush and exception request high, the redirect low, no retire lane valid, and the flush PC equal to the faulting entry's PC.
- R9: A branch head (dispatched with its branch bit set) that completed with its mispredict flag set also waits one cycle. In its `ST_FLUSH` cycle it retires on lane 0 with its result, redirect is high, the exception request is low, and the flush PC equals the completion's target. If both flags are set, the exception takes priority.
- R10: The mispredict flag of an entry dispatched without the branch bit is ignored: that entry retires normally and no flush occurs.
- R11: After `ST_FLUSH` the buffer is empty and tags restart at 0. During `ST_FLUSH` dispatch ready is low and offered dispatch is not written.
- R12: Pointers wrap modulo DEPTH: tags assigned after the wrap restart at 0, and retirement proceeds across the wrap in order.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| disp_valid_i | input | DISP_W | Dispatch lane valids, contiguous from lane 0 |
| disp_pc_i | input | DISP_W*PC_W | PC per dispatch lane |
| disp_dest_i | input | DISP_W*AREG_W | Architectural destination per lane |
| disp_br_i | input | DISP_W | Lane holds a conditional branch |
| disp_ready_o | output | 1 | Dispatch accepted this cycle |
| disp_tag_o | output | DISP_W*IDX_W | Tag that each lane would receive |
| cmp_valid_i | input | 1 | Completion writeback valid |
| cmp_tag_i | input | IDX_W | Tag of the completing entry |
| cmp_data_i | input | XLEN | Result value |
| cmp_exc_i | input | 1 | Instruction raised an exception |
| cmp_misp_i | input | 1 | Branch was mispredicted |
| cmp_target_i | input | PC_W | Correct branch target |
| ret_valid_o | output | RET_W | Retire lane valids |
| ret_tag_o | output | RET_W*IDX_W | Tag per retire lane |
| ret_dest_o | output | RET_W*AREG_W | Destination per retire lane |
| ret_data_o | output | RET_W*XLEN | Result per retire lane |
| flush_o | output | 1 | Buffer flush this cycle |
| redir_o | output | 1 | Fetch redirect (mispredict) |
| exc_o | output | 1 | Exception handler request |
| flush_pc_o | output | PC_W | Redirect target or faulting PC |

## Verification
The bench builds the buffer with DEPTH 8, three dispatch and three retire lanes, 16-bit results and PCs, and 4-bit destinations. The shallow depth lets two dispatch bursts of three reach the backpressure point, where only two entries are free. It also makes the tags wrap past 7 to 0 within a few cycles, so a full three-lane retire group can be seen straddling the wrap. Each flush scenario needs only a handful of entries, so it can be observed cycle by cycle from dispatch through the detection cycle to the return to an empty buffer.

// File: rtl/rob_pkg.sv
package rob_pkg;

    typedef enum logic [0:0] {
        ST_RUN   = 1'b0,
        ST_FLUSH = 1'b1
    } rob_state_e;

endpackage

// File: rtl/rob_ctrl.sv
module rob_ctrl
    import rob_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic head_fault_i,
    output logic run_o,
    output logic flush_o
);

    rob_state_e state_q;

    // State register with its transitions
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state_q <= ST_RUN;
        end else begin
            unique case (state_q)
                ST_RUN:   if (head_fault_i) state_q <= ST_FLUSH;
                ST_FLUSH: state_q <= ST_RUN;
                default:  state_q <= ST_RUN;
            endcase
        end
    end

    // Outputs decoded from the state
    always_comb begin
        unique case (state_q)
            ST_RUN: begin
                run_o   = 1'b1;
                flush_o = 1'b0;
            end
            ST_FLUSH: begin
                run_o   = 1'b0;
                flush_o = 1'b1;
            end
            default: begin
                run_o   = 1'b0;
                flush_o = 1'b0;
            end
        endcase
    end

endmodule

// File: rtl/rob_retire_pick.sv
module rob_retire_pick #(
    parameter int DEPTH = 16,
    parameter int RET_W = 3,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic [IDX_W-1:0]            head_idx_i,
    input  logic [DEPTH-1:0]            ok_vec_i,
    output logic [RET_W-1:0]            lane_v_o,
    output logic [RET_W-1:0][IDX_W-1:0] lane_idx_o
);

    // Each lane may leave only if every lane before it leaves too
    always_comb begin
        logic run;
        run = 1'b1;
        for (int i = 0; i < RET_W; i++) begin
            lane_idx_o[i] = head_idx_i + IDX_W'(i);
            run           = run & ok_vec_i[lane_idx_o[i]];
            lane_v_o[i]   = run;
        end
    end

endmodule

// File: rtl/rob_core.sv
module rob_core #(
    parameter int DEPTH  = 16,
    parameter int DISP_W = 3,
    parameter int RET_W  = 3,
    parameter int XLEN   = 32,
    parameter int PC_W   = 32,
    parameter int AREG_W = 4,
    localparam int IDX_W = $clog2(DEPTH)
) (
    input  logic                     clk,
    input  logic                     rst_n,
    input  logic [DISP_W-1:0]        disp_valid_i,
    input  logic [DISP_W*PC_W-1:0]   disp_pc_i,
    input  logic [DISP_W*AREG_W-1:0] disp_dest_i,
    input  logic [DISP_W-1:0]        disp_br_i,
    output logic                     disp_ready_o,
    output logic [DISP_W*IDX_W-1:0]  disp_tag_o,
    input  logic                     cmp_valid_i,
    input  logic [IDX_W-1:0]         cmp_tag_i,
    input  logic [XLEN-1:0]          cmp_data_i,
    input  logic                     cmp_exc_i,
    input  logic                     cmp_misp_i,
    input  logic [PC_W-1:0]          cmp_target_i,
    output logic [RET_W-1:0]         ret_valid_o,
    output logic [RET_W*IDX_W-1:0]   ret_tag_o,
    output logic [RET_W*AREG_W-1:0]  ret_dest_o,
    output logic [RET_W*XLEN-1:0]    ret_data_o,
    output logic                     flush_o,
    output logic                     redir_o,
    output logic                     exc_o,
    output logic [PC_W-1:0]          flush_pc_o
);

    localparam int PTR_W = IDX_W + 1;

    logic [PTR_W-1:0]  head_q, tail_q;
    logic [DEPTH-1:0]  v_q, done_q, exc_q, mis_q, br_q;
    logic [PC_W-1:0]   pc_q   [DEPTH];
    logic [PC_W-1:0]   tgt_q  [DEPTH];
    logic [AREG_W-1:0] dest_q [DEPTH];
    logic [XLEN-1:0]   data_q [DEPTH];

    logic [IDX_W-1:0]  head_idx, tail_idx;
    logic [PTR_W-1:0]  used, free_n, n_disp, n_ret;
    logic [DEPTH-1:0]  fault_vec, ok_vec;
    logic              head_fault, head_exc, head_misp;
    logic              run, in_flush, cmp_take;
    logic [RET_W-1:0]            lane_v;
    logic [RET_W-1:0][IDX_W-1:0] lane_idx;

    assign head_idx = head_q[IDX_W-1:0];
    assign tail_idx = tail_q[IDX_W-1:0];
    assign used     = tail_q - head_q;
    assign free_n   = PTR_W'(DEPTH) - used;

    always_comb begin
        fault_vec = exc_q | (mis_q & br_q);
        ok_vec    = v_q & done_q & ~fault_vec;
    end

    assign head_fault = v_q[head_idx] & done_q[head_idx] & fault_vec[head_idx];
    assign head_exc   = exc_q[head_idx];
    assign head_misp  = ~exc_q[head_idx] & mis_q[head_idx] & br_q[head_idx];

    rob_ctrl u_ctrl (
        .clk          (clk),
        .rst_n        (rst_n),
        .head_fault_i (head_fault),
        .run_o        (run),
        .flush_o      (in_flush)
    );

    rob_retire_pick #(.DEPTH(DEPTH), .RET_W(RET_W)) u_pick (
        .head_idx_i (head_idx),
        .ok_vec_i   (ok_vec),
        .lane_v_o   (lane_v),
        .lane_idx_o (lane_idx)
    );

    // Dispatch side
    assign disp_ready_o = run && (free_n >= PTR_W'(DISP_W));
    assign n_disp       = PTR_W'($countones(disp_valid_i));

    always_comb begin
        for (int i = 0; i < DISP_W; i++) begin
            disp_tag_o[i*IDX_W +: IDX_W] = tail_idx + IDX_W'(i);
        end
    end

    // Retire side
    always_comb begin
        for (int i = 0; i < RET_W; i++) begin
            ret_valid_o[i] = run ? lane_v[i] : ((i == 0) && head_misp);
            ret_tag_o[i*IDX_W +: IDX_W]     = lane_idx[i];
            ret_dest_o[i*AREG_W +: AREG_W]  = dest_q[lane_idx[i]];
            ret_data_o[i*XLEN +: XLEN]      = data_q[lane_idx[i]];
        end
    end
    assign n_ret = PTR_W'($countones(ret_valid_o));

    // Flush / redirect side
    assign flush_o    = in_flush;
    assign exc_o      = in_flush & head_exc;
    assign redir_o    = in_flush & head_misp;
    assign flush_pc_o = !in_flush ? '0 :
                        (head_exc ? pc_q[head_idx] : tgt_q[head_idx]);

    assign cmp_take = run && cmp_valid_i && v_q[cmp_tag_i] && !done_q[cmp_tag_i];

    // Entry flags and pointers
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            head_q <= '0;
            tail_q <= '0;
            v_q    <= '0;
            done_q <= '0;
            exc_q  <= '0;
            mis_q  <= '0;
            br_q   <= '0;
        end else if (in_flush) begin
            head_q <= '0;
            tail_q <= '0;
            v_q    <= '0;
            done_q <= '0;
        end else begin
            if (cmp_take) begin
                done_q[cmp_tag_i] <= 1'b1;
                exc_q[cmp_tag_i]  <= cmp_exc_i;
                mis_q[cmp_tag_i]  <= cmp_misp_i;
            end
            for (int i = 0; i < RET_W; i++) begin
                if (ret_valid_o[i]) begin
                    v_q[lane_idx[i]]    <= 1'b0;
                    done_q[lane_idx[i]] <= 1'b0;
                end
            end
            if (disp_ready_o) begin
                for (int i = 0; i < DISP_W; i++) begin
                    if (disp_valid_i[i]) begin
                        v_q[tail_idx + IDX_W'(i)]    <= 1'b1;
                        done_q[tail_idx + IDX_W'(i)] <= 1'b0;
                        exc_q[tail_idx + IDX_W'(i)]  <= 1'b0;
                        mis_q[tail_idx + IDX_W'(i)]  <= 1'b0;
                        br_q[tail_idx + IDX_W'(i)]   <= disp_br_i[i];
                    end
                end
                tail_q <= tail_q + n_disp;
            end
            head_q <= head_q + n_ret;
        end
    end

    // Payload storage, no reset needed
    always_ff @(posedge clk) begin
        if (cmp_take) begin
            data_q[cmp_tag_i] <= cmp_data_i;
            tgt_q[cmp_tag_i]  <= cmp_target_i;
        end
        if (disp_ready_o) begin
            for (int i = 0; i < DISP_W; i++) begin
                if (disp_valid_i[i]) begin
                    pc_q[tail_idx + IDX_W'(i)]   <= disp_pc_i[i*PC_W +: PC_W];
                    dest_q[tail_idx + IDX_W'(i)] <= disp_dest_i[i*AREG_W +: AREG_W];
                end
            end
        end
    end

endmodule

// File: rtl/rob_chk.sv
module rob_chk #(
    parameter int DEPTH = 16,
    parameter int RET_W = 3,
    localparam int IDX_W = $clog2(DEPTH),
    localparam int PTR_W = IDX_W + 1
) (
    input logic                   clk,
    input logic                   rst_n,
    input logic [RET_W-1:0]       ret_valid_o,
    input logic [RET_W*IDX_W-1:0] ret_tag_o,
    input logic                   flush_o,
    input logic                   redir_o,
    input logic                   exc_o,
    input logic                   disp_ready_o,
    input logic [PTR_W-1:0]       head_q,
    input logic [PTR_W-1:0]       tail_q
);

    // R3: occupancy bounded by the depth
    assert_no_overflow_R3: assert property (@(posedge clk) disable iff (!rst_n)
        (PTR_W'(tail_q - head_q) <= PTR_W'(DEPTH)));

    for (genvar i = 1; i < RET_W; i++) begin : g_lane
        // R5: lanes fill from lane 0 without gaps
        assert_lane_contig_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid_o[i] |-> ret_valid_o[i-1]);
        // R5: neighbouring lanes carry consecutive tags
        assert_lane_order_R5: assert property (@(posedge clk) disable iff (!rst_n)
            ret_valid_o[i] |-> (ret_tag_o[i*IDX_W +: IDX_W] ==
                                ret_tag_o[(i-1)*IDX_W +: IDX_W] + IDX_W'(1)));
    end

    // R8: flush lasts exactly one cycle
    assert_flush_single_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> !flush_o);

    // R8: a flush has exactly one cause
    assert_one_cause_R8: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> $onehot({exc_o, redir_o}));

    // R8: an exception retires nothing
    assert_exc_no_retire_R8: assert property (@(posedge clk) disable iff (!rst_n)
        exc_o |-> (ret_valid_o == '0));

    // R9: a redirect only appears with a flush
    assert_redir_flush_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (redir_o || exc_o) |-> flush_o);

    // R11: dispatch is closed while flushing
    assert_flush_block_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |-> !disp_ready_o);

    // R11: the buffer is empty after a flush
    assert_flush_empty_R11: assert property (@(posedge clk) disable iff (!rst_n)
        flush_o |=> ((tail_q == head_q) && (ret_valid_o == '0)));

endmodule

bind rob_core rob_chk #(.DEPTH(DEPTH), .RET_W(RET_W)) u_chk (
    .clk          (clk),
    .rst_n        (rst_n),
    .ret_valid_o  (ret_valid_o),
    .ret_tag_o    (ret_tag_o),
    .flush_o      (flush_o),
    .redir_o      (redir_o),
    .exc_o        (exc_o),
    .disp_ready_o (disp_ready_o),
    .head_q       (head_q),
    .tail_q       (tail_q)
);

// File: tb/sim_rob_core.sv
`timescale 1ns/1ps
module sim_rob_core;

    localparam int DEPTH  = 8;
    localparam int DISP_W = 3;
    localparam int RET_W  = 3;
    localparam int XLEN   = 16;
    localparam int PC_W   = 16;
    localparam int AREG_W = 4;
    localparam int IDX_W  = 3;

    logic                     clk = 1'b0;
    logic                     rst_n;
    logic [DISP_W-1:0]        disp_valid_i;
    logic [DISP_W*PC_W-1:0]   disp_pc_i;
    logic [DISP_W*AREG_W-1:0] disp_dest_i;
    logic [DISP_W-1:0]        disp_br_i;
    logic                     disp_ready_o;
    logic [DISP_W*IDX_W-1:0]  disp_tag_o;
    logic                     cmp_valid_i;
    logic [IDX_W-1:0]         cmp_tag_i;
    logic [XLEN-1:0]          cmp_data_i;
    logic                     cmp_exc_i;
    logic                     cmp_misp_i;
    logic [PC_W-1:0]          cmp_target_i;
    logic [RET_W-1:0]         ret_valid_o;
    logic [RET_W*IDX_W-1:0]   ret_tag_o;
    logic [RET_W*AREG_W-1:0]  ret_dest_o;
    logic [RET_W*XLEN-1:0]    ret_data_o;
    logic                     flush_o, redir_o, exc_o;
    logic [PC_W-1:0]          flush_pc_o;

    int n_chk  = 0;
    int n_fail = 0;

    always #10 clk = ~clk;

    rob_core #(.DEPTH(DEPTH), .DISP_W(DISP_W), .RET_W(RET_W), .XLEN(XLEN),
               .PC_W(PC_W), .AREG_W(AREG_W)) u0 (.*);

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    function automatic int rtag(input int i);
        return int'(ret_tag_o[i*IDX_W +: IDX_W]);
    endfunction
    function automatic int rdata(input int i);
        return int'(ret_data_o[i*XLEN +: XLEN]);
    endfunction
    function automatic int dtag(input int i);
        return int'(disp_tag_o[i*IDX_W +: IDX_W]);
    endfunction

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    task automatic idle();
        disp_valid_i = '0; disp_pc_i = '0; disp_dest_i = '0; disp_br_i = '0;
        cmp_valid_i = 1'b0; cmp_tag_i = '0; cmp_data_i = '0;
        cmp_exc_i = 1'b0; cmp_misp_i = 1'b0; cmp_target_i = '0;
    endtask

    task automatic do_reset();
        idle();
        rst_n = 1'b0;
        repeat (2) @(posedge clk);
        #1 rst_n = 1'b1;
    endtask

    task automatic disp(input int n, input int pc0, input logic [DISP_W-1:0] br);
        for (int i = 0; i < DISP_W; i++) begin
            disp_valid_i[i] = (i < n);
            disp_pc_i[i*PC_W +: PC_W] = PC_W'(pc0 + 4*i);
            disp_dest_i[i*AREG_W +: AREG_W] = AREG_W'(i + 1);
        end
        disp_br_i = br;
        tick();
        disp_valid_i = '0;
        disp_br_i = '0;
    endtask

    task automatic cmp(input int tag, input int data, input bit exc,
                       input bit misp, input int tgt);
        cmp_valid_i = 1'b1; cmp_tag_i = IDX_W'(tag); cmp_data_i = XLEN'(data);
        cmp_exc_i = exc; cmp_misp_i = misp; cmp_target_i = PC_W'(tgt);
        tick();
        cmp_valid_i = 1'b0; cmp_exc_i = 1'b0; cmp_misp_i = 1'b0;
    endtask

    task automatic t_reset();
        do_reset();
        chk("R1 ret_valid", int'(ret_valid_o), 0);
        chk("R1 flush", int'(flush_o), 0);
        chk("R1 ready", int'(disp_ready_o), 1);
        chk("R1 tag lane0", dtag(0), 0);
        chk("R1 tag lane2", dtag(2), 2);
    endtask

    task automatic t_order();
        do_reset();
        disp(3, 'h100, '0);
        chk("R2 tail after 3", dtag(0), 3);
        cmp(2, 22, 0, 0, 0);
        chk("R6 head blocks done younger", int'(ret_valid_o), 0);
        cmp(0, 10, 0, 0, 0);
        chk("R5 single retire", int'(ret_valid_o), 1);
        chk("R5 lane0 data", rdata(0), 10);
        cmp(1, 11, 0, 0, 0);
        chk("R5 two retire", int'(ret_valid_o), 3);
        chk("R5 lane0 tag", rtag(0), 1);
        chk("R5 lane1 tag", rtag(1), 2);
        chk("R5 lane1 data", rdata(1), 22);
        chk("R5 lane0 dest", int'(ret_dest_o[0 +: AREG_W]), 2);
        tick();
        chk("R5 drained", int'(ret_valid_o), 0);
    endtask

    task automatic t_burst();
        do_reset();
        cmp(3, 99, 0, 0, 0);                // R4: empty slot
        disp(3, 'h180, '0);
        chk("R2 tag before 2nd burst", dtag(0), 3);
        disp(1, 'h18c, '0);
        cmp(2, 20, 0, 0, 0);
        cmp(2, 77, 0, 0, 0);                // R4: already done
        cmp(1, 21, 0, 0, 0);
        cmp(0, 19, 0, 0, 0);
        chk("R5 three lanes", int'(ret_valid_o), 7);
        chk("R5 lane2 tag", rtag(2), 2);
        chk("R4 repeat completion ignored", rdata(2), 20);
        tick();
        chk("R4 empty-slot completion ignored", int'(ret_valid_o), 0);
        cmp(3, 33, 0, 0, 0);
        chk("R5 fourth entry", int'(ret_valid_o), 1);
        chk("R5 fourth tag", rtag(0), 3);
        chk("R4 fourth data", rdata(0), 33);
        tick();
    endtask

    task automatic t_exc();
        do_reset();
        disp(3, 'h200, '0);
        cmp(1, 0, 1, 0, 0);
        cmp(2, 2, 0, 0, 0);
        cmp(0, 1, 0, 0, 0);
        chk("R7 older retires", int'(ret_valid_o), 1);
        chk("R7 older tag", rtag(0), 0);
        chk("R7 no flush yet", int'(flush_o), 0);
        tick();
        chk("R8 detect cycle no retire", int'(ret_valid_o), 0);
        chk("R8 detect cycle no flush", int'(flush_o), 0);
        tick();
        chk("R8 flush", int'(flush_o), 1);
        chk("R8 exc", int'(exc_o), 1);
        chk("R8 redir", int'(redir_o), 0);
        chk("R8 pc", int'(flush_pc_o), 'h204);
        chk("R8 no retire", int'(ret_valid_o), 0);
        chk("R11 ready low", int'(disp_ready_o), 0);
        tick();
        chk("R11 back to run", int'(flush_o), 0);
        chk("R11 ready", int'(disp_ready_o), 1);
        chk("R11 tag restart", dtag(0), 0);
        chk("R11 empty", int'(ret_valid_o), 0);
    endtask

    task automatic t_misp();
        do_reset();
        disp(2, 'h300, 3'b001);
        cmp(1, 5, 0, 0, 0);
        cmp(0, 'h55, 0, 1, 'h1234);
        chk("R9 detect no retire", int'(ret_valid_o), 0);
        tick();
        chk("R9 flush", int'(flush_o), 1);
        chk("R9 redir", int'(redir_o), 1);
        chk("R9 exc", int'(exc_o), 0);
        chk("R9 target", int'(flush_pc_o), 'h1234);
        chk("R9 branch retires", int'(ret_valid_o), 1);
        chk("R9 branch data", rdata(0), 'h55);
        disp_valid_i = 3'b001;              // R11: offered during flush
        tick();
        disp_valid_i = '0;
        chk("R11 flush dispatch ignored", dtag(0), 0);
        chk("R11 nothing left", int'(ret_valid_o), 0);
    endtask

    task automatic t_nonbr();
        do_reset();
        disp(1, 'h400, '0);
        cmp(0, 7, 0, 1, 'h999);
        chk("R10 retires normally", int'(ret_valid_o), 1);
        chk("R10 data", rdata(0), 7);
        chk("R10 no flush", int'(flush_o), 0);
        tick();
        chk("R10 still no flush", int'(flush_o), 0);
        chk("R10 tail", dtag(0), 1);
    endtask

    task automatic t_wrap();
        do_reset();
        disp(3, 'h500, '0);
        disp(3, 'h50c, '0);
        chk("R3 ready low", int'(disp_ready_o), 0);
        disp_valid_i = 3'b111;
        tick();
        disp_valid_i = '0;
        chk("R3 tail held", dtag(0), 6);
        for (int t = 5; t >= 0; t--) cmp(t, 40 + t, 0, 0, 0);
        chk("R5 group A", int'(ret_valid_o), 7);
        chk("R5 group A lane0", rtag(0), 0);
        tick();
        chk("R5 group B", int'(ret_valid_o), 7);
        chk("R5 group B lane2", rtag(2), 5);
        tick();
        chk("R3 ready again", int'(disp_ready_o), 1);
        chk("R12 lane1 tag", dtag(1), 7);
        chk("R12 lane2 wraps", dtag(2), 0);
        disp(3, 'h600, '0);
        cmp(0, 3, 0, 0, 0);
        cmp(7, 2, 0, 0, 0);
        cmp(6, 1, 0, 0, 0);
        chk("R12 retire across wrap", int'(ret_valid_o), 7);
        chk("R12 lane0 tag", rtag(0), 6);
        chk("R12 lane2 tag", rtag(2), 0);
        chk("R12 lane2 data", rdata(2), 3);
        tick();
        chk("R12 drained", int'(ret_valid_o), 0);
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog all requirements actual=timeout expected=finish");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_order();
        t_burst();
        t_exc();
        t_misp();
        t_nonbr();
        t_wrap();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule